// File: doc/BRIEF.md
# Block-Transfer Micro-Op Sequencer

This block takes a single block-transfer instruction word and cracks it into an ordered stream of micro-operations. It issues one micro-operation per cycle on a valid/ready port. Each micro-operation carries:

- a kind code,
- a register index,
- a byte offset,
- a load flag,
- a synthesized 32-bit instruction word,
- a last marker.

A downstream pipeline consumes the stream. Memory access and register-file updates take place downstream.

The instruction supplies four things. The low 16 bits are a register list. The base register sits in bits [19:16]. The condition field sits in bits [31:28]. A five-bit mode code sits in bits [24:20], read as {pre, up, user, writeback, load}.

The stream always opens with a copy of the base register. It then holds one transfer per listed register, taken in ascending register order, with a running offset. If writeback is set, it closes with a base-update operation whose encoded immediate is four times the register count. The mode code selects the starting offset. A mode code outside the supported set sets a sticky error flag and produces no stream.

Top module: `ldm_crack_seq`

## Requirements
- R1: After reset, uop_valid_o and err_o are both 0.
- R2: An accepted supported instruction produces exactly n + W + 1 handshaken micro-ops, where n is the number of set bits in instr[15:0] and W is instr[21]. Only the final one has uop_last_o = 1, and uop_valid_o is 0 in the cycle after it is taken.
- R3: The first micro-op has kind 0 (base copy), register instr[19:16], offset 0, and word {instr[31:16], 16'h0000}. It is valid in the cycle after the start is accepted.
- R4: Transfer micro-ops have kind 1, word 0 and uop_load_o = instr[20]. Their register indices are the set bits of instr[15:0], in ascending order.
- R5: The first transfer offset depends on the mode code instr[24:20]. Codes 0x01 and 0x03 start at 4n-4. Codes 0x08, 0x09 and 0x0B start at 0. Codes 0x11 and 0x12 start at 4n. Codes 0x18 and 0x19 start at 4. The offset is 8 bits wide.
- R6: Each later transfer offset is the previous one plus 4 when instr[23] is 1, and minus 4 when it is 0.
- R7: When instr[21] = 1, the final micro-op has kind 2 (add) if instr[23] = 1, or kind 3 (subtract) otherwise. Its register is instr[19:16], its offset is 0, and its word is {instr[31:28], 28'h2400000} with the base number in bits [19:16] and in bits [15:12], and 4n in bits [7:0].
- R8: A start whose mode code is not one of the nine supported codes sets err_o in the next cycle and emits no micro-op. err_o stays set until a later accepted start with a supported code clears it.
- R9: start_i is accepted only when no micro-op is pending (uop_valid_o = 0). A start presented while busy leaves the current stream unchanged.
- R10: While uop_valid_o = 1 and uop_ready_i = 0, every micro-op output holds its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to crack instr_i |
| instr_i | input | 32 | Block-transfer instruction word |
| uop_ready_i | input | 1 | Consumer accepts the current micro-op |
| uop_valid_o | output | 1 | A micro-op is presented |
| uop_kind_o | output | 2 | 0 copy, 1 transfer, 2 add, 3 subtract |
| uop_reg_o | output | 4 | Register index |
| uop_ofs_o | output | 8 | Byte offset |
| uop_word_o | output | 32 | Synthesized instruction word |
| uop_load_o | output | 1 | Load (1) or store (0) |
| uop_last_o | output | 1 | Final micro-op of the stream |
| err_o | output | 1 | Sticky unsupported-mode flag |

## Verification
Two functions can meet in the same cycle:

- **New start while the stream is stalled or ending.** A start can arrive on a cycle when the current stream is stalled or is handing over its final micro-op. The bench drives start_i high with a different instruction partway through a stream, while the consumer's ready is randomly withheld. It then judges that the remaining micro-ops still match the first instruction and that the stream length is unchanged.
- **Clearing a pending error.** The cycle that clears a pending error is also the cycle that launches a new stream. After an unsupported code, a supported start must drop err_o and present the base copy together in the next cycle.

// File: rtl/ldm_crack_pkg.sv
package ldm_crack_pkg;

    typedef enum logic [1:0] {
        UOP_COPY = 2'd0,
        UOP_XFER = 2'd1,
        UOP_ADD  = 2'd2,
        UOP_SUB  = 2'd3
    } uop_kind_e;

    localparam logic [4:0] MODE_DA_L   = 5'h01;
    localparam logic [4:0] MODE_DA_WL  = 5'h03;
    localparam logic [4:0] MODE_IA_U   = 5'h08;
    localparam logic [4:0] MODE_IA_UL  = 5'h09;
    localparam logic [4:0] MODE_IA_UWL = 5'h0B;
    localparam logic [4:0] MODE_DB_L   = 5'h11;
    localparam logic [4:0] MODE_DB_W   = 5'h12;
    localparam logic [4:0] MODE_IB_U   = 5'h18;
    localparam logic [4:0] MODE_IB_UL  = 5'h19;

    localparam logic [31:0] WB_OPCODE = 32'h0240_0000;

endpackage

// File: rtl/ldm_popcount.sv
module ldm_popcount #(
    parameter int W     = 16,
    localparam int CW   = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < W; i++) begin
            cnt_o = cnt_o + CW'(vec_i[i]);
        end
    end
endmodule

// File: rtl/ldm_mode_decode.sv
module ldm_mode_decode
    import ldm_crack_pkg::*;
#(
    parameter int CW    = 5,
    parameter int OFS_W = 8
) (
    input  logic [4:0]       mode_i,
    input  logic [CW-1:0]    cnt_i,
    output logic             ok_o,
    output logic [OFS_W-1:0] start_ofs_o
);
    logic [OFS_W-1:0] span;

    always_comb begin
        span        = OFS_W'({cnt_i, 2'b00});
        ok_o        = 1'b1;
        start_ofs_o = '0;
        case (mode_i)
            MODE_DA_L, MODE_DA_WL:              start_ofs_o = span - OFS_W'(4);
            MODE_IA_U, MODE_IA_UL, MODE_IA_UWL: start_ofs_o = '0;
            MODE_DB_L, MODE_DB_W:               start_ofs_o = span;
            MODE_IB_U, MODE_IB_UL:              start_ofs_o = OFS_W'(4);
            default:                            ok_o        = 1'b0;
        endcase
    end
endmodule

// File: rtl/ldm_lowbit_pick.sv
module ldm_lowbit_pick #(
    parameter int W     = 16,
    localparam int IW   = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o,
    output logic [W-1:0]  rest_o
);
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
        any_o         = |vec_i;
        rest_o        = vec_i;
        rest_o[idx_o] = 1'b0;
    end
endmodule

// File: rtl/ldm_crack_seq.sv
module ldm_crack_seq
    import ldm_crack_pkg::*;
#(
    parameter int LIST_W = 16,
    parameter int OFS_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [31:0]      instr_i,
    input  logic             uop_ready_i,
    output logic             uop_valid_o,
    output logic [1:0]       uop_kind_o,
    output logic [3:0]       uop_reg_o,
    output logic [OFS_W-1:0] uop_ofs_o,
    output logic [31:0]      uop_word_o,
    output logic             uop_load_o,
    output logic             uop_last_o,
    output logic             err_o
);
    localparam int CW = $clog2(LIST_W + 1);
    localparam int IW = $clog2(LIST_W);

    typedef struct packed {
        logic              valid;
        uop_kind_e         kind;
        logic [3:0]        rreg;
        logic [OFS_W-1:0]  ofs;
        logic [31:0]       word;
        logic              last;
        logic [LIST_W-1:0] list;
        logic [OFS_W-1:0]  nofs;
        logic              up;
        logic              load;
        logic              wb;
        logic [3:0]        base;
        logic [3:0]        cond;
        logic [7:0]        span;
        logic              err;
    } seq_t;

    seq_t s_d, s_q;

    logic [CW-1:0]     in_cnt;
    logic              mode_ok;
    logic [OFS_W-1:0]  mode_ofs;
    logic              pk_any;
    logic [IW-1:0]     pk_idx;
    logic [LIST_W-1:0] pk_rest;
    logic              accept;
    logic              fire;

    ldm_popcount #(.W(LIST_W)) u_pop (
        .vec_i (instr_i[LIST_W-1:0]),
        .cnt_o (in_cnt)
    );

    ldm_mode_decode #(.CW(CW), .OFS_W(OFS_W)) u_mode (
        .mode_i      (instr_i[24:20]),
        .cnt_i       (in_cnt),
        .ok_o        (mode_ok),
        .start_ofs_o (mode_ofs)
    );

    ldm_lowbit_pick #(.W(LIST_W)) u_pick (
        .vec_i  (s_q.list),
        .any_o  (pk_any),
        .idx_o  (pk_idx),
        .rest_o (pk_rest)
    );

    assign accept = start_i && !s_q.valid;
    assign fire   = s_q.valid && uop_ready_i;

    always_comb begin
        s_d = s_q;
        if (accept) begin
            s_d.err = !mode_ok;
            if (mode_ok) begin
                s_d.valid = 1'b1;
                s_d.kind  = UOP_COPY;
                s_d.rreg  = instr_i[19:16];
                s_d.ofs   = '0;
                s_d.word  = {instr_i[31:16], 16'h0000};
                s_d.list  = instr_i[LIST_W-1:0];
                s_d.last  = (instr_i[LIST_W-1:0] == '0) && !instr_i[21];
                s_d.nofs  = mode_ofs;
                s_d.up    = instr_i[23];
                s_d.wb    = instr_i[21];
                s_d.load  = instr_i[20];
                s_d.base  = instr_i[19:16];
                s_d.cond  = instr_i[31:28];
                s_d.span  = 8'({in_cnt, 2'b00});
            end else begin
                s_d.valid = 1'b0;
            end
        end else if (fire) begin
            if (s_q.last) begin
                s_d.valid = 1'b0;
            end else if (pk_any) begin
                s_d.kind = UOP_XFER;
                s_d.rreg = 4'(pk_idx);
                s_d.ofs  = s_q.nofs;
                s_d.nofs = s_q.up ? s_q.nofs + OFS_W'(4) : s_q.nofs - OFS_W'(4);
                s_d.word = '0;
                s_d.list = pk_rest;
                s_d.last = (pk_rest == '0) && !s_q.wb;
            end else begin
                s_d.kind = s_q.up ? UOP_ADD : UOP_SUB;
                s_d.rreg = s_q.base;
                s_d.ofs  = '0;
                s_d.word = {s_q.cond, 28'h0} | WB_OPCODE
                         | {12'h0, s_q.base, s_q.base, 4'h0, s_q.span};
                s_d.last = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign uop_valid_o = s_q.valid;
    assign uop_kind_o  = s_q.kind;
    assign uop_reg_o   = s_q.rreg;
    assign uop_ofs_o   = s_q.ofs;
    assign uop_word_o  = s_q.word;
    assign uop_load_o  = s_q.load;
    assign uop_last_o  = s_q.last;
    assign err_o       = s_q.err;

    // R10: stalled micro-op holds
    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid_o && !uop_ready_i |=> uop_valid_o && $stable(uop_kind_o)
            && $stable(uop_reg_o) && $stable(uop_ofs_o) && $stable(uop_word_o)
            && $stable(uop_last_o));

    // R2: taking the last micro-op ends the stream
    a_r2_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid_o && uop_ready_i && uop_last_o |=> !uop_valid_o);

    // R8: error state emits nothing
    a_r8_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !uop_valid_o);

    // R3: every stream opens with a base copy
    a_r3_first_copy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uop_valid_o) |-> uop_kind_o == UOP_COPY && uop_ofs_o == '0);

    // R9: a start seen while busy does not restart the stream
    a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid_o && !uop_ready_i && start_i |=> uop_valid_o && $stable(uop_kind_o)
            && $stable(uop_reg_o));

endmodule

// File: tb/ldm_crack_seq_test.sv
module ldm_crack_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic        uop_ready_i = 1'b0;
    logic        uop_valid_o;
    logic [1:0]  uop_kind_o;
    logic [3:0]  uop_reg_o;
    logic [7:0]  uop_ofs_o;
    logic [31:0] uop_word_o;
    logic        uop_load_o;
    logic        uop_last_o;
    logic        err_o;

    int checks = 0;
    int failures = 0;

    logic [1:0]  e_kind [0:17];
    logic [3:0]  e_reg  [0:17];
    logic [7:0]  e_ofs  [0:17];
    logic [31:0] e_word [0:17];
    logic        e_last [0:17];
    int          e_num;

    ldm_crack_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .uop_ready_i(uop_ready_i), .uop_valid_o(uop_valid_o),
        .uop_kind_o(uop_kind_o), .uop_reg_o(uop_reg_o), .uop_ofs_o(uop_ofs_o),
        .uop_word_o(uop_word_o), .uop_load_o(uop_load_o),
        .uop_last_o(uop_last_o), .err_o(err_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit mode_ok(input logic [4:0] m);
        return m inside {5'h01, 5'h03, 5'h08, 5'h09, 5'h0B, 5'h11, 5'h12, 5'h18, 5'h19};
    endfunction

    function automatic void build_expect(input logic [31:0] ins);
        int n;
        logic [7:0] o;
        logic [3:0] rn;
        int k;
        n  = $countones(ins[15:0]);
        rn = ins[19:16];
        case (ins[24:20])
            5'h01, 5'h03: o = 8'(4 * n - 4);
            5'h11, 5'h12: o = 8'(4 * n);
            5'h18, 5'h19: o = 8'd4;
            default:      o = 8'd0;
        endcase
        e_kind[0] = 2'd0; e_reg[0] = rn; e_ofs[0] = 8'd0;
        e_word[0] = {ins[31:16], 16'h0};
        k = 1;
        for (int r = 0; r < 16; r++) begin
            if (ins[r]) begin
                e_kind[k] = 2'd1; e_reg[k] = 4'(r); e_ofs[k] = o; e_word[k] = 32'h0;
                o = ins[23] ? o + 8'd4 : o - 8'd4;
                k++;
            end
        end
        if (ins[21]) begin
            e_kind[k] = ins[23] ? 2'd2 : 2'd3;
            e_reg[k]  = rn;
            e_ofs[k]  = 8'd0;
            e_word[k] = {ins[31:28], 4'h2, 4'h4, rn, rn, 4'h0, 8'(4 * n)};
            k++;
        end
        for (int i = 0; i < 18; i++) e_last[i] = (i == k - 1);
        e_num = k;
    endfunction

    task automatic run_seq(input logic [31:0] ins, input int stall_pct, input bit poke);
        int idx;
        int guard;
        build_expect(ins);
        @(negedge clk);
        start_i = 1'b1; instr_i = ins;
        @(negedge clk);
        start_i = 1'b0;
        check(err_o == 1'b0, "R8 err cleared by good start", 32'(err_o), 32'h0);
        idx = 0; guard = 0;
        while (idx < e_num && guard < 2000) begin
            start_i = 1'b0;
            check(uop_valid_o == 1'b1, "R2 stream valid", 32'(uop_valid_o), 32'h1);
            if (uop_valid_o) begin
                check(32'(uop_kind_o) == 32'(e_kind[idx]), "R3/R4/R7 kind",
                      32'(uop_kind_o), 32'(e_kind[idx]));
                check(uop_reg_o == e_reg[idx], "R4 register", 32'(uop_reg_o),
                      32'(e_reg[idx]));
                check(uop_ofs_o == e_ofs[idx], "R5/R6 offset", 32'(uop_ofs_o),
                      32'(e_ofs[idx]));
                check(uop_word_o == e_word[idx], "R3/R7 word", uop_word_o, e_word[idx]);
                check(uop_last_o == e_last[idx], "R2 last flag", 32'(uop_last_o),
                      32'(e_last[idx]));
                if (e_kind[idx] == 2'd1)
                    check(uop_load_o == ins[20], "R4 load flag", 32'(uop_load_o),
                          32'(ins[20]));
            end
            if (poke && guard == 1) begin
                start_i = 1'b1;
                instr_i = {4'h3, 3'b100, 5'h18, 4'h9, 16'h00F0};
            end
            uop_ready_i = (($urandom % 100) >= 32'(stall_pct));
            if (uop_valid_o && uop_ready_i) idx++;
            guard++;
            @(negedge clk);
        end
        start_i = 1'b0;
        uop_ready_i = 1'b0;
        check(uop_valid_o == 1'b0, "R2 stream length", 32'(uop_valid_o), 32'h0);
    endtask

    task automatic run_bad(input logic [31:0] ins);
        @(negedge clk);
        start_i = 1'b1; instr_i = ins;
        @(negedge clk);
        start_i = 1'b0;
        uop_ready_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            check(err_o == 1'b1, "R8 error raised", 32'(err_o), 32'h1);
            check(uop_valid_o == 1'b0, "R8 no micro-op", 32'(uop_valid_o), 32'h0);
            @(negedge clk);
        end
        uop_ready_i = 1'b0;
    endtask

    function automatic logic [31:0] rand_instr(input bit allow_bad);
        logic [4:0] m;
        logic [15:0] lst;
        case ($urandom % 9)
            0: m = 5'h01; 1: m = 5'h03; 2: m = 5'h08; 3: m = 5'h09; 4: m = 5'h0B;
            5: m = 5'h11; 6: m = 5'h12; 7: m = 5'h18; default: m = 5'h19;
        endcase
        if (allow_bad && ($urandom % 6 == 0)) m = 5'($urandom);
        lst = 16'($urandom);
        if ($urandom % 3 == 0) lst = lst & 16'($urandom);
        return {4'($urandom), 3'b100, m, 4'($urandom), lst};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] ins;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(uop_valid_o == 1'b0, "R1 reset valid", 32'(uop_valid_o), 32'h0);
        check(err_o == 1'b0, "R1 reset err", 32'(err_o), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(uop_valid_o == 1'b0, "R1 idle after reset", 32'(uop_valid_o), 32'h0);

        // directed corners
        run_seq({4'hE, 3'b100, 5'h0B, 4'hD, 16'hFFFF}, 0, 1'b0);   // R5 R6 R7 full list add
        run_seq({4'h1, 3'b100, 5'h12, 4'h2, 16'h8001}, 50, 1'b0);  // R7 subtract, R5 4n
        run_seq({4'h0, 3'b100, 5'h01, 4'h0, 16'h0000}, 0, 1'b0);   // R2 copy only
        run_seq({4'hA, 3'b100, 5'h03, 4'h5, 16'h0000}, 30, 1'b0);  // R7 wb with n=0
        run_seq({4'h7, 3'b100, 5'h19, 4'hF, 16'h0404}, 60, 1'b1);  // R9 start while busy
        run_bad({4'h0, 3'b100, 5'h00, 4'h1, 16'h00FF});            // R8
        run_bad({4'h0, 3'b100, 5'h1F, 4'h1, 16'h00FF});            // R8 error stays
        run_seq({4'h2, 3'b100, 5'h11, 4'h6, 16'h1234}, 20, 1'b0);  // R8 cleared, R5

        for (int t = 0; t < 80; t++) begin
            ins = rand_instr(1'b1);
            if (mode_ok(ins[24:20])) run_seq(ins, int'($urandom % 70), ($urandom % 4) == 0);
            else run_bad(ins);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule